// File: doc/BRIEF.md
# Zero-suppressing pixel chip reader

This block collects one event from a single pixel readout chip and keeps only the words that carry hits. A level-1 accept pulse starts the sequence. The block first raises the next-event-read line toward the chip for one cycle. It then holds chip enable high for exactly one event's worth of word cycles, and the chip presents one 32-bit word per cycle.

An internal word counter with a count enable and a carry-out tracks the position of each word within the event. Words whose bits are all zero are discarded. Each remaining word is paired with its zero-extended position and pushed into an on-block synchronous FIFO, 64 bits wide and 256 entries deep. The carry-out of the counter ends the event. A downstream consumer drains the FIFO through a first-word-fall-through read port.

If the FIFO is full when a hit word arrives, that word is lost and a sticky overflow flag is raised. Only a reset clears the flag.

Top module: `pixel_zs_reader`

## Requirements
- R1: After reset, chip_en, next_evt_rd, evt_done and overflow are 0 and fifo_empty is 1 with fifo_full 0.
- R2: A level-1 accept while idle makes next_evt_rd high for exactly one cycle on the following cycle, after which chip_en is high for exactly 256 consecutive cycles; the two lines are never high together.
- R3: A word that is all zeros while chip_en is high is never written into the FIFO.
- R4: Each stored entry holds the pixel word in bits 63:32 and its word index (0 to 255) zero-extended in bits 31:0, and entries leave the FIFO in the order the words arrived.
- R5: The cycle after the 256th word, evt_done is high for exactly one cycle, then the block returns to idle and accepts a new level-1 accept.
- R6: A level-1 accept that arrives while a readout is in progress has no effect: no second next_evt_rd pulse and no extra chip_en cycles.
- R7: The FIFO holds 256 entries, presents the oldest entry on fifo_rd_data while fifo_empty is 0, advances one entry per cycle with fifo_rd_en, and ignores fifo_rd_en while empty; fifo_full and fifo_empty are never both high.
- R8: A non-zero word that arrives while the FIFO is full is dropped and sets overflow, which stays high until reset.
- R9: The word index restarts at 0 for the first word of every event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l1_accept | input | 1 | Level-1 accept pulse that starts a readout |
| chip_data | input | 32 | Word presented by the pixel chip |
| chip_en | output | 1 | Chip enable, high during the word cycles |
| next_evt_rd | output | 1 | One-cycle request for the chip to load the next event |
| evt_done | output | 1 | One-cycle pulse after the last word |
| fifo_rd_en | input | 1 | Pops the oldest FIFO entry |
| fifo_rd_data | output | 64 | Oldest FIFO entry: word in 63:32, index in 31:0 |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds 256 entries |
| overflow | output | 1 | Sticky flag: a hit word was dropped on a full FIFO |

## Verification
The bench places hit words at index 0 and index 255, and words with only bit 0 or only bit 31 set. A design with an off-by-one counter would mislabel them or lose the last word. A zero test that looks at only part of the word would keep or drop the wrong ones. An all-zero event must leave the FIFO empty. An all-hit event must fill it to exactly 256 entries without raising overflow. A following event must then set overflow while the stored data stays intact, which catches a FIFO that wraps over old entries. A level-1 accept injected mid-readout and a pop on an empty FIFO are checked at the ports. A design that restarted the handshake would show two request pulses, and one that underflowed its pointers would return garbage for the next event.

// File: rtl/pzr_pkg.sv
package pzr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQUEST = 2'd1,
        ST_READ    = 2'd2,
        ST_DONE    = 2'd3
    } rd_state_e;

endpackage

// File: rtl/pzr_word_counter.sv
module pzr_word_counter #(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cnt_en,
    output logic [IDX_W-1:0] cnt,
    output logic             cout
);

    typedef struct packed {
        logic [IDX_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.cnt = '0;
        end else if (cnt_en) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt  = r_q.cnt;
    assign cout = cnt_en && (r_q.cnt == {IDX_W{1'b1}});

endmodule

// File: rtl/pzr_sync_fifo.sv
module pzr_sync_fifo #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_regs_t;

    fifo_regs_t r_d, r_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             do_wr;
    logic             do_rd;

    always_comb begin
        r_d   = r_q;
        do_wr = wr_en && (r_q.count != DEPTH_C);
        do_rd = rd_en && (r_q.count != '0);
        if (do_wr) begin
            r_d.wr_ptr = (r_q.wr_ptr == LAST_C) ? '0 : r_q.wr_ptr + 1'b1;
        end
        if (do_rd) begin
            r_d.rd_ptr = (r_q.rd_ptr == LAST_C) ? '0 : r_q.rd_ptr + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   r_d.count = r_q.count + 1'b1;
            2'b01:   r_d.count = r_q.count - 1'b1;
            default: r_d.count = r_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem_q[r_q.wr_ptr] <= wr_data;
        end
    end

    assign rd_data = mem_q[r_q.rd_ptr];
    assign empty   = (r_q.count == '0);
    assign full    = (r_q.count == DEPTH_C);

endmodule

// File: rtl/pzr_read_ctrl.sv
module pzr_read_ctrl
    import pzr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l1_accept,
    input  logic [DATA_W-1:0] chip_data,
    input  logic              cnt_cout,
    input  logic              fifo_full,
    output logic              chip_en,
    output logic              next_evt_rd,
    output logic              evt_done,
    output logic              cnt_clr,
    output logic              cnt_en,
    output logic              fifo_wr_en,
    output logic              overflow
);

    typedef struct packed {
        rd_state_e state;
        logic      ovf;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;
    logic       in_read;
    logic       hit;

    always_comb begin
        r_d     = r_q;
        in_read = (r_q.state == ST_READ);
        hit     = in_read && (chip_data != '0);
        case (r_q.state)
            ST_IDLE:    if (l1_accept) r_d.state = ST_REQUEST;
            ST_REQUEST: r_d.state = ST_READ;
            ST_READ:    if (cnt_cout) r_d.state = ST_DONE;
            ST_DONE:    r_d.state = ST_IDLE;
            default:    r_d.state = ST_IDLE;
        endcase
        if (hit && fifo_full) begin
            r_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, ovf: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign chip_en     = (r_q.state == ST_READ);
    assign next_evt_rd = (r_q.state == ST_REQUEST);
    assign evt_done    = (r_q.state == ST_DONE);
    assign cnt_clr     = (r_q.state == ST_REQUEST);
    assign cnt_en      = in_read;
    assign fifo_wr_en  = hit && !fifo_full;
    assign overflow    = r_q.ovf;

endmodule

// File: rtl/pixel_zs_reader.sv
module pixel_zs_reader #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned EVT_WORDS  = 256,
    parameter int unsigned FIFO_DEPTH = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                l1_accept,
    input  logic [DATA_W-1:0]   chip_data,
    output logic                chip_en,
    output logic                next_evt_rd,
    output logic                evt_done,
    input  logic                fifo_rd_en,
    output logic [2*DATA_W-1:0] fifo_rd_data,
    output logic                fifo_empty,
    output logic                fifo_full,
    output logic                overflow
);

    localparam int unsigned IDX_W   = $clog2(EVT_WORDS);
    localparam int unsigned ENTRY_W = 2 * DATA_W;
    localparam int unsigned PAD_W   = DATA_W - IDX_W;

    logic               cnt_clr;
    logic               cnt_en;
    logic               cnt_cout;
    logic [IDX_W-1:0]   word_idx;
    logic               fifo_wr_en;
    logic [ENTRY_W-1:0] fifo_wr_data;

    pzr_word_counter #(
        .IDX_W (IDX_W)
    ) i_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .cnt_en (cnt_en),
        .cnt    (word_idx),
        .cout   (cnt_cout)
    );

    pzr_read_ctrl #(
        .DATA_W (DATA_W)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .l1_accept   (l1_accept),
        .chip_data   (chip_data),
        .cnt_cout    (cnt_cout),
        .fifo_full   (fifo_full),
        .chip_en     (chip_en),
        .next_evt_rd (next_evt_rd),
        .evt_done    (evt_done),
        .cnt_clr     (cnt_clr),
        .cnt_en      (cnt_en),
        .fifo_wr_en  (fifo_wr_en),
        .overflow    (overflow)
    );

    assign fifo_wr_data = {chip_data, {PAD_W{1'b0}}, word_idx};

    pzr_sync_fifo #(
        .WIDTH (ENTRY_W),
        .DEPTH (FIFO_DEPTH)
    ) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fifo_wr_en),
        .wr_data (fifo_wr_data),
        .rd_en   (fifo_rd_en),
        .rd_data (fifo_rd_data),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

endmodule

// File: rtl/pzr_checks.sv
module pzr_checks #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] chip_data,
    input logic              chip_en,
    input logic              next_evt_rd,
    input logic              evt_done,
    input logic              fifo_empty,
    input logic              fifo_full,
    input logic              overflow,
    input logic              wr_en,
    input logic [IDX_W-1:0]  word_idx
);

    // R2
    request_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_evt_rd |=> (!next_evt_rd && chip_en));

    // R2
    request_enable_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(next_evt_rd && chip_en));

    // R3
    zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && chip_data == '0) |-> !wr_en);

    // R5
    done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> (!evt_done && !chip_en && !next_evt_rd));

    // R7
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R9
    index_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_en) |-> (word_idx == '0));

endmodule

bind pixel_zs_reader pzr_checks #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) i_pzr_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_data   (chip_data),
    .chip_en     (chip_en),
    .next_evt_rd (next_evt_rd),
    .evt_done    (evt_done),
    .fifo_empty  (fifo_empty),
    .fifo_full   (fifo_full),
    .overflow    (overflow),
    .wr_en       (fifo_wr_en),
    .word_idx    (word_idx)
);

// File: tb/test_pixel_zs_reader.sv
module test_pixel_zs_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l1_accept = 1'b0;
    logic [31:0] chip_data = '0;
    logic        chip_en;
    logic        next_evt_rd;
    logic        evt_done;
    logic        fifo_rd_en = 1'b0;
    logic [63:0] fifo_rd_data;
    logic        fifo_empty;
    logic        fifo_full;
    logic        overflow;

    always #5 clk = ~clk;

    pixel_zs_reader i_pixel_zs_reader (
        .clk          (clk),
        .rst_n        (rst_n),
        .l1_accept    (l1_accept),
        .chip_data    (chip_data),
        .chip_en      (chip_en),
        .next_evt_rd  (next_evt_rd),
        .evt_done     (evt_done),
        .fifo_rd_en   (fifo_rd_en),
        .fifo_rd_data (fifo_rd_data),
        .fifo_empty   (fifo_empty),
        .fifo_full    (fifo_full),
        .overflow     (overflow)
    );

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          finished = 1'b0;

    logic [31:0] words [256];
    logic [63:0] exp_q [256];
    int unsigned exp_n;
    int unsigned src_k;
    int unsigned ner_cnt, ce_cnt, done_cnt;

    // chip model and handshake monitor
    always @(negedge clk) begin
        if (next_evt_rd) begin
            ner_cnt++;
            src_k = 0;
        end
        if (chip_en) begin
            chip_data = words[src_k[7:0]];
            src_k++;
            ce_cnt++;
        end else begin
            chip_data = '0;
        end
        if (evt_done) done_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void build_exp();
        exp_n = 0;
        for (int i = 0; i < 256; i++) begin
            if (words[i] != 32'h0) begin
                exp_q[exp_n] = {words[i], 32'(i)};
                exp_n++;
            end
        end
    endfunction

    task automatic fill_random(input int unsigned occ_pct);
        for (int i = 0; i < 256; i++) begin
            if (($urandom % 100) < occ_pct) begin
                words[i] = $urandom | 32'h1;
            end else begin
                words[i] = 32'h0;
            end
        end
    endtask

    task automatic run_event(input bit inject);
        ner_cnt = 0; ce_cnt = 0; done_cnt = 0;
        @(negedge clk); l1_accept = 1'b1;
        @(negedge clk); l1_accept = 1'b0;
        for (int c = 0; c < 400 && done_cnt == 0; c++) begin
            @(negedge clk); #1;
            if (inject && c == 30) l1_accept = 1'b1;
            if (inject && c == 31) l1_accept = 1'b0;
        end
        repeat (8) @(negedge clk);
        #1;
        chk(ner_cnt == 1, "R2/R6 request pulses", 64'(ner_cnt), 64'd1);
        chk(ce_cnt == 256, "R2/R6 chip_en cycles", 64'(ce_cnt), 64'd256);
        chk(done_cnt == 1, "R5 done pulses", 64'(done_cnt), 64'd1);
        chk(!chip_en && !next_evt_rd, "R5 back to idle", {62'd0, chip_en, next_evt_rd}, 64'd0);
    endtask

    task automatic drain(input string tag);
        for (int j = 0; j < int'(exp_n); j++) begin
            @(negedge clk); #1;
            chk(!fifo_empty && fifo_rd_data == exp_q[j], tag, fifo_rd_data, exp_q[j]);
            fifo_rd_en = 1'b1;
        end
        @(negedge clk); fifo_rd_en = 1'b0; #1;
        chk(fifo_empty, "R7 empty after drain", {63'd0, fifo_empty}, 64'd1);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 256; i++) words[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(!chip_en && !next_evt_rd && !evt_done && !overflow && fifo_empty && !fifo_full,
            "R1 reset outputs", {58'd0, chip_en, next_evt_rd, evt_done, overflow, fifo_empty, fifo_full}, 64'h2);
        rst_n = 1'b1;

        // R4 R9 directed boundaries: hits at index 0 and 255, single-bit words
        fill_random(0);
        words[0] = 32'h0000_0001; words[1] = 32'h8000_0000;
        words[128] = 32'hdead_beef; words[255] = 32'h8000_0001;
        run_event(1'b0);
        build_exp();
        drain("R4 R9 boundary entry");

        // R3 all-zero event leaves FIFO empty
        fill_random(0);
        run_event(1'b0);
        #1;
        chk(fifo_empty, "R3 zero event empty", {63'd0, fifo_empty}, 64'd1);

        // R7 pop on empty ignored, next event still correct
        @(negedge clk); fifo_rd_en = 1'b1;
        @(negedge clk); fifo_rd_en = 1'b0; #1;
        chk(fifo_empty, "R7 pop on empty", {63'd0, fifo_empty}, 64'd1);

        // random events, one with a level-1 accept during readout (R6)
        for (int e = 0; e < 4; e++) begin
            fill_random(5 + 10 * e);
            run_event(e == 1);
            build_exp();
            drain("R4 random entry");
        end

        // R7 all-hit event fills FIFO exactly
        for (int i = 0; i < 256; i++) words[i] = $urandom | 32'h100;
        run_event(1'b0);
        build_exp();
        #1;
        chk(fifo_full && !overflow, "R7 full at 256 entries", {62'd0, fifo_full, overflow}, 64'h2);

        // R8 next event overflows; stored data untouched
        fill_random(0);
        words[7] = 32'h0000_0042;
        run_event(1'b0);
        #1;
        chk(overflow, "R8 overflow set", {63'd0, overflow}, 64'd1);
        drain("R8 data kept");
        chk(overflow, "R8 overflow sticky", {63'd0, overflow}, 64'd1);

        // R1 reset clears overflow
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        chk(!overflow && fifo_empty, "R1 reset clears", {62'd0, overflow, fifo_empty}, 64'd1);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule